// File: doc/BRIEF.md
# Packetized Byte Buffer with Word Host Port

This block is a 32-byte buffer that sits between a host register window and a card-side serial engine. The host side moves data only as whole 8-byte packets, each made of two 32-bit word transfers. The card side pushes or pops one byte at a time. The host and the card share one circular byte store. Each side can fill it for the other side to drain.

Within a host word, bytes are packed big-endian. The byte that comes first in the stream sits in bits 31..24. The host moves data through two valid/ready word ports. Both of them always accept, so the host sees no back-pressure. Instead, a whole packet that cannot be served is discarded, and a sticky error bit records it. A word counter on each host port wraps every two words and marks packet boundaries. The card side uses ordinary byte-wide valid/ready ports and does see back-pressure. A card push waits while the store is full or while a host packet write is under way. A card pop waits while the store is empty or while a host packet read is under way.

A host can poll the status outputs at any time: almost full, empty, card data received, and the two sticky errors. The active-low reset empties the store and clears every flag.

Top module: `pkt_sfifo`

## Requirements
- R1: The store holds 32 bytes, arranged as four 8-byte packets. The fill level never exceeds 32. A host packet write is accepted only if at least 8 bytes are free when its first word arrives, and then both of its words are stored.
- R2: Byte order is big-endian. A packet's first host word carries bytes 0..3 and its second word carries bytes 4..7. In each word, the earliest byte is in bits 31..24 and the latest is in bits 7..0.
- R3: A host read delivers a packet only if all 8 of its bytes are present when the first word is requested. A partial packet is never delivered and is left in the store untouched.
- R4: When fewer than 8 bytes are free at the first word of a host write, both words of that packet are dropped. `err_wr` then rises and stays high until reset.
- R5: When fewer than 8 bytes are present at the first word of a host read, both words of that packet return 0 and consume nothing. `err_rd` then rises and stays high until reset.
- R6: `flag_afull` is high exactly when fewer than 8 bytes are free, meaning the last packet slot has been taken.
- R7: `flag_empty` is high exactly when the store holds no bytes.
- R8: `flag_rx` rises after a byte is accepted from the card. It falls once the store drains to empty in a cycle with no card push.
- R9: `cw_ready` is high only when the store is not full, no host write word is offered, and no host packet write is half done. `cr_valid` is high only when the store is not empty, no host read word is requested, and no host packet read is half done. `cr_byte` always shows the oldest byte.
- R10: `hw_ready` and `hr_ready` are always high. Each host word offered advances that port's word counter, which wraps after two words. Reset leaves the store empty, with `flag_empty` high and all other flags and errors low.
- R11: Bytes leave in the order they entered, including across the wrap of the store's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_valid | input | 1 | Host offers a write word |
| hw_ready | output | 1 | Write word taken (always high) |
| hw_data | input | 32 | Host write word, big-endian bytes |
| hr_valid | input | 1 | Host requests a read word |
| hr_ready | output | 1 | Read request taken (always high) |
| hr_data | output | 32 | Read word in the request cycle, 0 when refused |
| cw_valid | input | 1 | Card offers a byte |
| cw_ready | output | 1 | Card byte can be taken |
| cw_byte | input | 8 | Card byte in |
| cr_valid | output | 1 | Byte available to the card |
| cr_ready | input | 1 | Card takes the byte |
| cr_byte | output | 8 | Oldest byte in the store |
| flag_afull | output | 1 | No free packet slot left |
| flag_empty | output | 1 | Store is empty |
| flag_rx | output | 1 | Card data has arrived |
| err_wr | output | 1 | Sticky: a host write was dropped |
| err_rd | output | 1 | Sticky: a host read was refused |

## Verification
Several traffic patterns exercise the main path.
- Host packets drained byte by byte by the card check byte order and the empty transition.
- Card bytes collected as host words check word packing and the clearing of the received flag.
- Four host packets written across the address wrap, then read back, check ordering and the exact fill level at which the almost-full flag rises.
- A seven-byte partial packet tells apart "not yet visible" from "lost", because the refused read must leave all seven bytes for the delivery that follows.
- Attempted card traffic during a half-done host packet, and against a full store, must leave the returned data unchanged. This shows that blocked transfers really inserted or removed nothing.

// File: rtl/pkt_sfifo_pkg.sv
package pkt_sfifo_pkg;
  // Host port word geometry; the register window is fixed at 32 bits.
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_W     = WORD_BYTES * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pkt_sfifo_store.sv
module pkt_sfifo_store
  import pkt_sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_we,
  input  logic          byte_we,
  input  logic [AW-1:0] wr_ptr,
  input  word_t         wr_word,
  input  byte_t         wr_byte,
  input  logic [AW-1:0] rd_ptr,
  output word_t         rd_word,
  output byte_t         rd_byte
);
  byte_t mem [DEPTH];

  // Word writes scatter four lanes big-endian from wr_ptr; byte writes hit wr_ptr.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (word_we) begin
      for (int k = 0; k < WORD_BYTES; k++)
        mem[wr_ptr + AW'(k)] <= wr_word[WORD_W-1-BYTE_W*k -: BYTE_W];
    end else if (byte_we) begin
      mem[wr_ptr] <= wr_byte;
    end
  end

  // Gather lanes for the host read word; earliest byte lands in the top lane.
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign rd_word[WORD_W-1-BYTE_W*k -: BYTE_W] = mem[rd_ptr + AW'(k)];
  end

  assign rd_byte = mem[rd_ptr];
endmodule

// File: rtl/pkt_sfifo_ctrl.sv
module pkt_sfifo_ctrl
  import pkt_sfifo_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 8,
  parameter int unsigned NUM_PKTS  = 4,
  localparam int unsigned DEPTH = PKT_BYTES * NUM_PKTS,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1,
  localparam int unsigned WPP   = PKT_BYTES / WORD_BYTES,
  localparam int unsigned PW    = (WPP > 1) ? $clog2(WPP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_valid,
  input  logic          hr_valid,
  input  logic          cw_valid,
  input  logic          cr_ready,
  output logic          cw_ready,
  output logic          cr_valid,
  output logic          hw_store,
  output logic          hr_take,
  output logic          c_push,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] fill_q,
  output logic [CW-1:0] fill_nx,
  output logic          wr_first,
  output logic          rd_first,
  output logic          err_wr,
  output logic          err_rd
);
  localparam logic [CW-1:0] WSTEP   = CW'(WORD_BYTES);
  localparam logic [CW-1:0] PKT_CNT = CW'(PKT_BYTES);
  localparam logic [CW-1:0] FULL    = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PH = PW'(WPP - 1);

  logic [PW-1:0] wph_q, rph_q;
  logic          wdrop_q, rdrop_q;
  logic [CW-1:0] free_b;
  logic          w_room, r_avail, c_pop;

  assign wr_first = (wph_q == '0);
  assign rd_first = (rph_q == '0);
  assign free_b   = FULL - fill_q;
  assign w_room   = (free_b >= PKT_CNT);
  assign r_avail  = (fill_q >= PKT_CNT);

  // Admission is decided on the first word of a packet and held for the rest.
  assign hw_store = hw_valid && (wr_first ? w_room  : !wdrop_q);
  assign hr_take  = hr_valid && (rd_first ? r_avail : !rdrop_q);

  // Card side yields to any host packet in flight on the same pointer.
  assign cw_ready = (fill_q != FULL) && !hw_valid && wr_first;
  assign cr_valid = (fill_q != '0)   && !hr_valid && rd_first;
  assign c_push   = cw_valid && cw_ready;
  assign c_pop    = cr_valid && cr_ready;

  always_comb begin
    fill_nx = fill_q;
    if (hw_store) fill_nx = fill_nx + WSTEP;
    if (c_push)   fill_nx = fill_nx + CW'(1);
    if (hr_take)  fill_nx = fill_nx - WSTEP;
    if (c_pop)    fill_nx = fill_nx - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wph_q   <= '0;
      rph_q   <= '0;
      wdrop_q <= 1'b0;
      rdrop_q <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill_q  <= '0;
      err_wr  <= 1'b0;
      err_rd  <= 1'b0;
    end else begin
      fill_q <= fill_nx;
      if (hw_valid) begin
        wph_q <= (wph_q == LAST_PH) ? '0 : wph_q + PW'(1);
        if (wr_first) wdrop_q <= !w_room;
        if (wr_first && !w_room) err_wr <= 1'b1;
      end
      if (hr_valid) begin
        rph_q <= (rph_q == LAST_PH) ? '0 : rph_q + PW'(1);
        if (rd_first) rdrop_q <= !r_avail;
        if (rd_first && !r_avail) err_rd <= 1'b1;
      end
      if (hw_store)    wr_ptr <= wr_ptr + AW'(WORD_BYTES);
      else if (c_push) wr_ptr <= wr_ptr + AW'(1);
      if (hr_take)     rd_ptr <= rd_ptr + AW'(WORD_BYTES);
      else if (c_pop)  rd_ptr <= rd_ptr + AW'(1);
    end
  end
endmodule

// File: rtl/pkt_sfifo_flags.sv
module pkt_sfifo_flags #(
  parameter int unsigned PKT_BYTES = 8,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill_q,
  input  logic [CW-1:0] fill_nx,
  input  logic          c_push,
  output logic          flag_afull,
  output logic          flag_empty,
  output logic          flag_rx
);
  logic [CW-1:0] free_b;
  assign free_b     = CW'(DEPTH) - fill_q;
  assign flag_afull = (free_b < CW'(PKT_BYTES));
  assign flag_empty = (fill_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_rx <= 1'b0;
    else if (c_push)         flag_rx <= 1'b1;
    else if (fill_nx == '0)  flag_rx <= 1'b0;
  end
endmodule

// File: rtl/pkt_sfifo.sv
module pkt_sfifo
  import pkt_sfifo_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 8,
  parameter int unsigned NUM_PKTS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_valid,
  output logic        hw_ready,
  input  logic [31:0] hw_data,
  input  logic        hr_valid,
  output logic        hr_ready,
  output logic [31:0] hr_data,
  input  logic        cw_valid,
  output logic        cw_ready,
  input  logic [7:0]  cw_byte,
  output logic        cr_valid,
  input  logic        cr_ready,
  output logic [7:0]  cr_byte,
  output logic        flag_afull,
  output logic        flag_empty,
  output logic        flag_rx,
  output logic        err_wr,
  output logic        err_rd
);
  localparam int unsigned DEPTH = PKT_BYTES * NUM_PKTS;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CW    = AW + 1;

  logic          hw_store, hr_take, c_push;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill_cnt, fill_nx;
  logic          wr_first, rd_first;
  word_t         rd_word;

  assign hw_ready = 1'b1;
  assign hr_ready = 1'b1;

  pkt_sfifo_ctrl #(.PKT_BYTES(PKT_BYTES), .NUM_PKTS(NUM_PKTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hw_valid(hw_valid), .hr_valid(hr_valid),
    .cw_valid(cw_valid), .cr_ready(cr_ready),
    .cw_ready(cw_ready), .cr_valid(cr_valid),
    .hw_store(hw_store), .hr_take(hr_take), .c_push(c_push),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .fill_q(fill_cnt), .fill_nx(fill_nx),
    .wr_first(wr_first), .rd_first(rd_first),
    .err_wr(err_wr), .err_rd(err_rd)
  );

  pkt_sfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .word_we(hw_store), .byte_we(c_push),
    .wr_ptr(wr_ptr), .wr_word(hw_data), .wr_byte(cw_byte),
    .rd_ptr(rd_ptr), .rd_word(rd_word), .rd_byte(cr_byte)
  );

  pkt_sfifo_flags #(.PKT_BYTES(PKT_BYTES), .DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .fill_q(fill_cnt), .fill_nx(fill_nx), .c_push(c_push),
    .flag_afull(flag_afull), .flag_empty(flag_empty), .flag_rx(flag_rx)
  );

  assign hr_data = hr_take ? rd_word : '0;
endmodule

// File: rtl/pkt_sfifo_chk.sv
module pkt_sfifo_chk #(
  parameter int unsigned PKT   = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_valid,
  input logic          hr_valid,
  input logic          cw_valid,
  input logic          cw_ready,
  input logic          cr_valid,
  input logic          cr_ready,
  input logic          flag_afull,
  input logic          flag_empty,
  input logic          flag_rx,
  input logic          err_wr,
  input logic          err_rd,
  input logic [CW-1:0] fill_cnt,
  input logic          wr_first,
  input logic          rd_first
);
  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  // R1
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_valid && !hr_valid && !(cw_valid && cw_ready) && !(cr_valid && cr_ready))
    |=> $stable(fill_cnt));

  // R4
  wr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr |=> err_wr);

  // R4
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && wr_first && flag_afull) |=> err_wr);

  // R5
  rd_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rd |=> err_rd);

  // R5
  rd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_valid && rd_first && (fill_cnt < CW'(PKT))) |=> err_rd);

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> !flag_empty);

  // R9
  push_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ready |-> (!hw_valid && !flag_afull || !hw_valid && wr_first));

  // R8
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_ready) |=> flag_rx);
endmodule

bind pkt_sfifo pkt_sfifo_chk #(.PKT(PKT_BYTES), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hw_valid(hw_valid), .hr_valid(hr_valid),
  .cw_valid(cw_valid), .cw_ready(cw_ready),
  .cr_valid(cr_valid), .cr_ready(cr_ready),
  .flag_afull(flag_afull), .flag_empty(flag_empty), .flag_rx(flag_rx),
  .err_wr(err_wr), .err_rd(err_rd),
  .fill_cnt(fill_cnt), .wr_first(wr_first), .rd_first(rd_first)
);

// File: tb/pkt_sfifo_bench.sv
`timescale 1ns/100ps
module pkt_sfifo_bench;
  localparam logic [1:0] OP_HW = 2'd0, OP_HR = 2'd1, OP_PUSH = 2'd2, OP_POP = 2'd3;
  localparam int NV = 40;
  // {op, data in, expected data, expected flags {afull,empty,rx,err_wr,err_rd}}
  localparam logic [70:0] VECS [NV] = '{
    {OP_HW,   32'h01020304, 32'h0, 5'b00000},
    {OP_HW,   32'h05060708, 32'h0, 5'b00000},
    {OP_POP,  32'h0, 32'h01, 5'b00000},
    {OP_POP,  32'h0, 32'h02, 5'b00000},
    {OP_POP,  32'h0, 32'h03, 5'b00000},
    {OP_POP,  32'h0, 32'h04, 5'b00000},
    {OP_POP,  32'h0, 32'h05, 5'b00000},
    {OP_POP,  32'h0, 32'h06, 5'b00000},
    {OP_POP,  32'h0, 32'h07, 5'b00000},
    {OP_POP,  32'h0, 32'h08, 5'b01000},
    {OP_PUSH, 32'hA0, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA1, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA2, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA3, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA4, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA5, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA6, 32'h0, 5'b00100},
    {OP_PUSH, 32'hA7, 32'h0, 5'b00100},
    {OP_HR,   32'h0, 32'hA0A1A2A3, 5'b00100},
    {OP_HR,   32'h0, 32'hA4A5A6A7, 5'b01000},
    {OP_HW,   32'h11121314, 32'h0, 5'b00000},
    {OP_HW,   32'h15161718, 32'h0, 5'b00000},
    {OP_HW,   32'h21222324, 32'h0, 5'b00000},
    {OP_HW,   32'h25262728, 32'h0, 5'b00000},
    {OP_HW,   32'h31323334, 32'h0, 5'b00000},
    {OP_HW,   32'h35363738, 32'h0, 5'b00000},
    {OP_HW,   32'h41424344, 32'h0, 5'b10000},
    {OP_HW,   32'h45464748, 32'h0, 5'b10000},
    {OP_HW,   32'hDEADBEEF, 32'h0, 5'b10010},
    {OP_HW,   32'hCAFEF00D, 32'h0, 5'b10010},
    {OP_HR,   32'h0, 32'h11121314, 5'b10010},
    {OP_HR,   32'h0, 32'h15161718, 5'b00010},
    {OP_HR,   32'h0, 32'h21222324, 5'b00010},
    {OP_HR,   32'h0, 32'h25262728, 5'b00010},
    {OP_HR,   32'h0, 32'h31323334, 5'b00010},
    {OP_HR,   32'h0, 32'h35363738, 5'b00010},
    {OP_HR,   32'h0, 32'h41424344, 5'b00010},
    {OP_HR,   32'h0, 32'h45464748, 5'b01010},
    {OP_HR,   32'h0, 32'h00000000, 5'b01011},
    {OP_HR,   32'h0, 32'h00000000, 5'b01011}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_valid = 1'b0, hr_valid = 1'b0, cw_valid = 1'b0, cr_ready = 1'b0;
  logic [31:0] hw_data = '0;
  logic [7:0]  cw_byte = '0;
  logic hw_ready, hr_ready, cw_ready, cr_valid;
  logic [31:0] hr_data;
  logic [7:0]  cr_byte;
  logic flag_afull, flag_empty, flag_rx, err_wr, err_rd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pkt_sfifo u_pkt_sfifo (
    .clk(clk), .rst_n(rst_n),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_data(hw_data),
    .hr_valid(hr_valid), .hr_ready(hr_ready), .hr_data(hr_data),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_byte(cw_byte),
    .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_byte(cr_byte),
    .flag_afull(flag_afull), .flag_empty(flag_empty), .flag_rx(flag_rx),
    .err_wr(err_wr), .err_rd(err_rd)
  );

  function automatic logic [4:0] flags();
    return {flag_afull, flag_empty, flag_rx, err_wr, err_rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; samples combinational outputs before the
  // rising edge and returns after the next falling edge with inputs idle.
  task automatic step(input logic [1:0] op, input logic [31:0] din,
                      output logic [31:0] got, output logic hs);
    hw_valid = (op == OP_HW);
    hw_data  = din;
    hr_valid = (op == OP_HR);
    cw_valid = (op == OP_PUSH);
    cw_byte  = din[7:0];
    cr_ready = (op == OP_POP);
    #1;
    case (op)
      OP_HW:   begin got = '0;               hs = hw_ready; end
      OP_HR:   begin got = hr_data;          hs = hr_ready; end
      OP_PUSH: begin got = '0;               hs = cw_ready; end
      default: begin got = {24'h0, cr_byte}; hs = cr_valid; end
    endcase
    @(negedge clk);
    hw_valid = 1'b0; hr_valid = 1'b0; cw_valid = 1'b0; cr_ready = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic hs;
    do_reset();

    // R10 R7: reset state
    chk(flags() == 5'b01000, "R10 reset flags", {27'h0, flags()}, 32'h08);
    chk(!cr_valid && cw_ready && hw_ready && hr_ready, "R10 reset handshakes",
        {28'h0, cr_valid, cw_ready, hw_ready, hr_ready}, 32'h7);

    // Vector table: R2 R6 R7 R8 R11 R4 R5 main traffic
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] din, exp;
      logic [4:0]  fl;
      {op, din, exp, fl} = VECS[i];
      step(op, din, got, hs);
      if (op == OP_HR || op == OP_POP)
        chk(got == exp && hs, "R2/R11 data", got, exp);
      else
        chk(hs, "R9/R10 handshake", {31'h0, hs}, 32'h1);
      chk(flags() == fl, "R4/R5/R6/R7/R8 flags", {27'h0, flags()}, {27'h0, fl});
    end

    // R10: reset clears sticky errors
    do_reset();
    chk(flags() == 5'b01000, "R10 errors cleared", {27'h0, flags()}, 32'h08);

    // R3: partial packet stays hidden and intact
    for (int b = 0; b < 7; b++) step(OP_PUSH, 32'h50 + b, got, hs);
    step(OP_HR, 32'h0, got, hs);
    chk(got == 32'h0, "R3 partial word0", got, 32'h0);
    step(OP_HR, 32'h0, got, hs);
    chk(got == 32'h0, "R5 refused word1", got, 32'h0);
    chk(err_rd && !flag_empty, "R3 partial kept", {30'h0, err_rd, flag_empty}, 32'h2);
    step(OP_PUSH, 32'h57, got, hs);
    step(OP_HR, 32'h0, got, hs);
    chk(got == 32'h50515253, "R3 full packet word0", got, 32'h50515253);
    step(OP_HR, 32'h0, got, hs);
    chk(got == 32'h54555657, "R2 full packet word1", got, 32'h54555657);
    chk(flag_empty && !flag_rx, "R8 rx cleared on drain", {30'h0, flag_empty, flag_rx}, 32'h2);

    // R1 R9: card fill to capacity, push refused when full
    do_reset();
    for (int b = 0; b < 32; b++) begin
      step(OP_PUSH, 32'(b), got, hs);
      if (!hs) chk(1'b0, "R9 push ready while space", {31'h0, hs}, 32'h1);
    end
    chk(!cw_ready && flag_afull, "R1 full", {30'h0, cw_ready, flag_afull}, 32'h1);
    step(OP_PUSH, 32'hEE, got, hs);
    chk(!hs, "R9 push refused when full", {31'h0, hs}, 32'h0);
    for (int w = 0; w < 8; w++) begin
      logic [31:0] e;
      e = {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)};
      step(OP_HR, 32'h0, got, hs);
      chk(got == e, "R11 full drain order", got, e);
    end
    chk(flag_empty, "R7 empty after drain", {31'h0, flag_empty}, 32'h1);

    // R9 R10: card side yields to half-done host packets
    do_reset();
    step(OP_HW, 32'h61626364, got, hs);
    step(OP_PUSH, 32'h99, got, hs);
    chk(!hs, "R9 push blocked mid write packet", {31'h0, hs}, 32'h0);
    step(OP_HW, 32'h65666768, got, hs);
    step(OP_HR, 32'h0, got, hs);
    chk(got == 32'h61626364, "R10 word counter word0", got, 32'h61626364);
    step(OP_POP, 32'h0, got, hs);
    chk(!hs, "R9 pop blocked mid read packet", {31'h0, hs}, 32'h0);
    step(OP_HR, 32'h0, got, hs);
    chk(got == 32'h65666768, "R9 no stray byte", got, 32'h65666768);
    chk(flags() == 5'b01000, "R7 empty after packet", {27'h0, flags()}, 32'h08);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule